// File: doc/BRIEF.md
# Segment-Masking Address Decoder

This block sits between a 32-bit processor's load/store unit and the system bus. It takes a virtual address, removes the segment bits by applying a mask chosen from the top three address bits, and then finds which fixed physical window the resulting address falls in. For that window it reports a one-hot target select and the byte offset from the window's base. It also classifies the access. An access can be forwarded to a target, it can be accepted with no effect, or it can be rejected because it is unaligned, malformed or unmapped.

Several control windows accept stores but discard them. The system-control window lets a store through only when the value matches an expected base address. Loads from the first expansion window return a fixed all-ones pattern. When the processor has its cache isolated, every store is dropped before it reaches the bus. The result of each request is registered once and presented one cycle later, qualified by a valid strobe.

Top module: `addr_decoder`

## Requirements
- R1: The physical address is derived from the virtual address using address bits [31:29] as the segment code. Codes 4 and 5 apply the masks 0x7FFFFFFF and 0x1FFFFFFF. The other six codes leave the address unchanged.
- R2: Windows match on base <= physical < base + size. The select bits are: bit0 main RAM 0x00000000 (2 MiB), bit1 boot ROM 0x1FC00000 (512 KiB), bit2 expansion-1 0x1F000000 (512 KiB), bit3 system control 0x1F801000 (36 B), bit4 memory-size 0x1F801060 (4 B), bit5 interrupt control 0x1F801070 (8 B), bit6 cache control 0xFFFE0130 (4 B), bit7 sound 0x1F801C00 (640 B), bit8 expansion-2 0x1F802000 (66 B). rsp_offset is the physical address minus the matched base, or 0 when nothing matches.
- R3: Size codes are 0 byte, 1 halfword, 2 word and 3 reserved. An access raises rsp_error when it is a word with address bits [1:0] nonzero, a halfword with bit 0 set, or size code 3.
- R4: A store made while cache_isolate is 1 sets rsp_ignore, clears rsp_error and selects nothing, even when the store is unaligned or unmapped.
- R5: An access that matches no window raises rsp_error.
- R6: Stores to the memory-size, interrupt-control and cache-control windows set rsp_ignore. Loads from these windows are selected normally.
- R7: Halfword stores to the sound window set rsp_ignore. Byte or word stores there raise rsp_error.
- R8: Byte stores to expansion-2 set rsp_ignore. Halfword or word stores there raise rsp_error.
- R9: A store to system-control offset 0 is ignored if req_wdata equals 0x1F000000 and raises an error otherwise. A store to offset 4 is ignored if req_wdata equals 0x1F802000 and raises an error otherwise. A store to any other offset in that window is ignored.
- R10: A load from expansion-1 that raises no error returns rsp_rdata = 0xFFFFFFFF. In every other case rsp_rdata is 0.
- R11: Outputs are registered. rsp_valid follows req_valid one cycle later. While rsp_valid is 0, and after reset, every other output is 0.
- R12: rsp_sel is one-hot or zero. It is zero whenever rsp_error or rsp_ignore is set, and otherwise it equals the matched window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | 32 | Virtual address |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 reserved |
| req_write | input | 1 | 1 store, 0 load |
| req_wdata | input | 32 | Store data, used for value checks |
| cache_isolate | input | 1 | Cache-isolate status bit |
| rsp_valid | output | 1 | Response valid, one cycle after request |
| rsp_sel | output | 9 | One-hot target window select |
| rsp_offset | output | 32 | Offset inside the matched window |
| rsp_ignore | output | 1 | Store accepted with no effect |
| rsp_error | output | 1 | Unaligned, malformed or unmapped access |
| rsp_rdata | output | 32 | Fixed read data for open expansion space |

## Verification
The bench aims at the last byte inside each window and the first byte past it. An off-by-one range compare would show up there as a wrong select or a missing error. It runs stores while the cache is isolated to misaligned and unmapped addresses. A design that checks alignment before the isolate bit would report an error where a silent drop is expected. It also sends each store size to the sound and expansion-2 windows, and correct and incorrect values to the system-control checks. Swapped size rules or a dropped compare would surface as an ignore and an error trading places. The same addresses are repeated through the masked segments to catch a wrong mask entry.

// File: rtl/addr_dec_pkg.sv
package addr_dec_pkg;

    localparam int AW   = 32;
    localparam int NREG = 9;
    localparam int SEGW = 3;

    // window indices (bit positions in the select vector)
    localparam int RG_RAM   = 0;
    localparam int RG_BOOT  = 1;
    localparam int RG_EXP1  = 2;
    localparam int RG_SYS   = 3;
    localparam int RG_MSIZE = 4;
    localparam int RG_IRQ   = 5;
    localparam int RG_CACHE = 6;
    localparam int RG_SOUND = 7;
    localparam int RG_EXP2  = 8;

    localparam logic [AW-1:0] SYS_EXPECT0 = 32'h1F00_0000;
    localparam logic [AW-1:0] SYS_EXPECT4 = 32'h1F80_2000;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } acc_size_e;

    typedef struct packed {
        logic [NREG-1:0] sel;
        logic [AW-1:0]   offset;
        logic            ignore;
        logic            error;
        logic [AW-1:0]   rdata;
    } dec_rsp_t;

    function automatic logic [AW-1:0] seg_mask(input logic [SEGW-1:0] seg);
        case (seg)
            3'd4:    return 32'h7FFF_FFFF;
            3'd5:    return 32'h1FFF_FFFF;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

    function automatic logic [AW-1:0] rgn_base(input int idx);
        case (idx)
            RG_RAM:   return 32'h0000_0000;
            RG_BOOT:  return 32'h1FC0_0000;
            RG_EXP1:  return 32'h1F00_0000;
            RG_SYS:   return 32'h1F80_1000;
            RG_MSIZE: return 32'h1F80_1060;
            RG_IRQ:   return 32'h1F80_1070;
            RG_CACHE: return 32'hFFFE_0130;
            RG_SOUND: return 32'h1F80_1C00;
            default:  return 32'h1F80_2000;
        endcase
    endfunction

    function automatic logic [AW-1:0] rgn_size(input int idx);
        case (idx)
            RG_RAM:   return 32'h0020_0000;
            RG_BOOT:  return 32'h0008_0000;
            RG_EXP1:  return 32'h0008_0000;
            RG_SYS:   return 32'd36;
            RG_MSIZE: return 32'd4;
            RG_IRQ:   return 32'd8;
            RG_CACHE: return 32'd4;
            RG_SOUND: return 32'd640;
            default:  return 32'd66;
        endcase
    endfunction

endpackage

// File: rtl/seg_mask_unit.sv
module seg_mask_unit
    import addr_dec_pkg::*;
(
    input  logic [AW-1:0] virt,
    output logic [AW-1:0] phys
);
    always_comb phys = virt & seg_mask(virt[AW-1 -: SEGW]);
endmodule

// File: rtl/region_match.sv
module region_match
    import addr_dec_pkg::*;
(
    input  logic [AW-1:0]   phys,
    output logic [NREG-1:0] hit,
    output logic [AW-1:0]   offset
);
    logic [AW-1:0] rel [NREG];

    for (genvar i = 0; i < NREG; i++) begin : g_win
        localparam logic [AW-1:0] WBASE = rgn_base(i);
        localparam logic [AW-1:0] WSIZE = rgn_size(i);
        always_comb begin
            rel[i] = phys - WBASE;
            hit[i] = (phys >= WBASE) && (rel[i] < WSIZE);
        end
    end

    always_comb begin
        offset = '0;
        for (int i = 0; i < NREG; i++)
            if (hit[i]) offset = offset | rel[i];
    end
endmodule

// File: rtl/access_policy.sv
module access_policy
    import addr_dec_pkg::*;
(
    input  logic [NREG-1:0] hit,
    input  logic [AW-1:0]   offset,
    input  logic [1:0]      low_bits,
    input  acc_size_e       size,
    input  logic            write,
    input  logic [AW-1:0]   wdata,
    input  logic            isolate,
    output dec_rsp_t        rsp
);
    logic misaligned;
    logic mapped;
    logic ign, err;

    always_comb begin
        misaligned = (size == SZ_RSVD)
                   || (size == SZ_WORD && low_bits != 2'b00)
                   || (size == SZ_HALF && low_bits[0]);
        mapped = |hit;
    end

    always_comb begin
        ign = 1'b0;
        err = 1'b0;
        if (write && isolate) begin
            ign = 1'b1;
        end else if (misaligned || !mapped) begin
            err = 1'b1;
        end else if (write) begin
            if (hit[RG_MSIZE] || hit[RG_IRQ] || hit[RG_CACHE]) begin
                ign = 1'b1;
            end else if (hit[RG_SOUND]) begin
                ign = (size == SZ_HALF);
                err = (size != SZ_HALF);
            end else if (hit[RG_EXP2]) begin
                ign = (size == SZ_BYTE);
                err = (size != SZ_BYTE);
            end else if (hit[RG_SYS]) begin
                if (offset == 32'd0) begin
                    ign = (wdata == SYS_EXPECT0);
                    err = (wdata != SYS_EXPECT0);
                end else if (offset == 32'd4) begin
                    ign = (wdata == SYS_EXPECT4);
                    err = (wdata != SYS_EXPECT4);
                end else begin
                    ign = 1'b1;
                end
            end
        end
    end

    always_comb begin
        rsp.sel    = (ign || err) ? '0 : hit;
        rsp.offset = offset;
        rsp.ignore = ign;
        rsp.error  = err;
        rsp.rdata  = (!write && !err && hit[RG_EXP1]) ? '1 : '0;
    end
endmodule

// File: rtl/addr_decoder.sv
module addr_decoder
    import addr_dec_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            req_valid,
    input  logic [31:0]     req_addr,
    input  logic [1:0]      req_size,
    input  logic            req_write,
    input  logic [31:0]     req_wdata,
    input  logic            cache_isolate,
    output logic            rsp_valid,
    output logic [8:0]      rsp_sel,
    output logic [31:0]     rsp_offset,
    output logic            rsp_ignore,
    output logic            rsp_error,
    output logic [31:0]     rsp_rdata
);
    logic [AW-1:0]   phys;
    logic [NREG-1:0] hit;
    logic [AW-1:0]   win_off;
    dec_rsp_t        nxt;
    dec_rsp_t        cur;
    logic            vld_q;

    seg_mask_unit u_mask (
        .virt (req_addr),
        .phys (phys)
    );

    region_match u_match (
        .phys   (phys),
        .hit    (hit),
        .offset (win_off)
    );

    access_policy u_policy (
        .hit      (hit),
        .offset   (win_off),
        .low_bits (phys[1:0]),
        .size     (acc_size_e'(req_size)),
        .write    (req_write),
        .wdata    (req_wdata),
        .isolate  (cache_isolate),
        .rsp      (nxt)
    );

    always_ff @(posedge clk) begin
        if (rst || !req_valid) begin
            cur   <= '0;
            vld_q <= 1'b0;
        end else begin
            cur   <= nxt;
            vld_q <= 1'b1;
        end
    end

    assign rsp_valid  = vld_q;
    assign rsp_sel    = cur.sel;
    assign rsp_offset = cur.offset;
    assign rsp_ignore = cur.ignore;
    assign rsp_error  = cur.error;
    assign rsp_rdata  = cur.rdata;
endmodule

// File: rtl/addr_decoder_chk.sv
module addr_decoder_chk (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic [31:0] req_addr,
    input logic [1:0]  req_size,
    input logic        req_write,
    input logic        cache_isolate,
    input logic        rsp_valid,
    input logic [8:0]  rsp_sel,
    input logic        rsp_ignore,
    input logic        rsp_error,
    input logic [31:0] rsp_rdata
);
    a_r12_sel_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(rsp_sel));

    a_r12_no_sel_on_flag: assert property (@(posedge clk) disable iff (rst)
        (rsp_error || rsp_ignore) |-> rsp_sel == '0);

    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !rsp_valid |-> (rsp_sel == '0 && !rsp_error && !rsp_ignore && rsp_rdata == '0));

    a_r11_valid_follows: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    a_r11_idle_follows: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);

    a_r4_isolated_store: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write && cache_isolate) |=> (rsp_ignore && !rsp_error));

    a_r3_word_misalign: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !(req_write && cache_isolate) && req_size == 2'd2 && req_addr[1:0] != 2'b00)
        |=> rsp_error);

    a_r10_rdata_only_ok: assert property (@(posedge clk) disable iff (rst)
        (rsp_rdata != '0) |-> (rsp_valid && !rsp_error && !rsp_ignore));
endmodule

bind addr_decoder addr_decoder_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .req_valid     (req_valid),
    .req_addr      (req_addr),
    .req_size      (req_size),
    .req_write     (req_write),
    .cache_isolate (cache_isolate),
    .rsp_valid     (rsp_valid),
    .rsp_sel       (rsp_sel),
    .rsp_ignore    (rsp_ignore),
    .rsp_error     (rsp_error),
    .rsp_rdata     (rsp_rdata)
);

// File: tb/tb_addr_decoder.sv
`timescale 1ns/1ps
module tb_addr_decoder;
    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic [31:0] req_addr;
    logic [1:0]  req_size;
    logic        req_write;
    logic [31:0] req_wdata;
    logic        cache_isolate;
    logic        rsp_valid;
    logic [8:0]  rsp_sel;
    logic [31:0] rsp_offset;
    logic        rsp_ignore;
    logic        rsp_error;
    logic [31:0] rsp_rdata;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    addr_decoder dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .req_size(req_size), .req_write(req_write), .req_wdata(req_wdata),
        .cache_isolate(cache_isolate), .rsp_valid(rsp_valid), .rsp_sel(rsp_sel),
        .rsp_offset(rsp_offset), .rsp_ignore(rsp_ignore), .rsp_error(rsp_error),
        .rsp_rdata(rsp_rdata)
    );

    // reference model, written from the requirements
    longint win_lo [9] = '{64'h0, 64'h1FC00000, 64'h1F000000, 64'h1F801000,
                           64'h1F801060, 64'h1F801070, 64'hFFFE0130,
                           64'h1F801C00, 64'h1F802000};
    longint win_len[9] = '{64'h200000, 64'h80000, 64'h80000, 36, 4, 8, 4, 640, 66};

    logic [8:0]  e_sel;
    logic [31:0] e_off;
    logic        e_ign, e_err;
    logic [31:0] e_rd;

    task automatic model(input logic [31:0] va, input int sz, input bit wr,
                         input logic [31:0] wd, input bit iso);
        logic [31:0] pa;
        int w;
        bit bad;
        pa = va;
        if (va[31:29] == 3'd4) pa = va & 32'h7FFFFFFF;
        if (va[31:29] == 3'd5) pa = va & 32'h1FFFFFFF;
        w = -1;
        for (int k = 0; k < 9; k++)
            if (longint'(pa) >= win_lo[k] && longint'(pa) < win_lo[k] + win_len[k]) w = k;
        e_off = (w >= 0) ? 32'(longint'(pa) - win_lo[w]) : 32'd0;
        bad = (sz == 3) || (sz == 2 && pa[1:0] != 0) || (sz == 1 && pa[0]);
        e_ign = 0; e_err = 0; e_rd = 0;
        if (wr && iso) e_ign = 1;
        else if (bad || w < 0) e_err = 1;
        else if (wr) begin
            if (w == 4 || w == 5 || w == 6) e_ign = 1;
            else if (w == 7) begin if (sz == 1) e_ign = 1; else e_err = 1; end
            else if (w == 8) begin if (sz == 0) e_ign = 1; else e_err = 1; end
            else if (w == 3) begin
                if (e_off == 0) begin if (wd == 32'h1F000000) e_ign = 1; else e_err = 1; end
                else if (e_off == 4) begin if (wd == 32'h1F802000) e_ign = 1; else e_err = 1; end
                else e_ign = 1;
            end
        end else if (w == 2) e_rd = 32'hFFFFFFFF;
        e_sel = (e_ign || e_err || w < 0) ? 9'd0 : 9'(1 << w);
    endtask

    task automatic compare(input string tag, input bit evld);
        checks++;
        if (rsp_valid !== evld || rsp_sel !== e_sel || rsp_offset !== e_off ||
            rsp_ignore !== e_ign || rsp_error !== e_err || rsp_rdata !== e_rd) begin
            errors++;
            $display("FAIL %s: got v=%0b sel=%h off=%h ign=%0b err=%0b rd=%h exp v=%0b sel=%h off=%h ign=%0b err=%0b rd=%h",
                     tag, rsp_valid, rsp_sel, rsp_offset, rsp_ignore, rsp_error, rsp_rdata,
                     evld, e_sel, e_off, e_ign, e_err, e_rd);
        end
    endtask

    task automatic go(input logic [31:0] va, input int sz, input bit wr,
                      input logic [31:0] wd, input bit iso, input string tag);
        @(negedge clk);
        req_valid = 1; req_addr = va; req_size = 2'(sz); req_write = wr;
        req_wdata = wd; cache_isolate = iso;
        model(va, sz, wr, wd, iso);
        @(posedge clk); #1;
        compare(tag, 1'b1);
    endtask

    task automatic idle(input string tag);
        @(negedge clk);
        req_valid = 0;
        req_addr = 32'h1F000000; req_size = 0; req_write = 0; cache_isolate = 0;
        e_sel = 0; e_off = 0; e_ign = 0; e_err = 0; e_rd = 0;
        @(posedge clk); #1;
        compare(tag, 1'b0);
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog: got timeout exp completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] picks [10] = '{32'h0, 32'h001FFFC0, 32'h1FC7FFC0, 32'h1F07FFC0,
                                    32'h1F801000, 32'h1F801060, 32'h1F801C00,
                                    32'h1F802000, 32'hFFFE0100, 32'h1F801200};
        rst = 1; req_valid = 1; req_addr = 32'h1F000000; req_size = 0;
        req_write = 0; req_wdata = 0; cache_isolate = 0;
        repeat (3) @(posedge clk);
        #1;
        e_sel = 0; e_off = 0; e_ign = 0; e_err = 0; e_rd = 0;
        compare("R11 reset", 1'b0);
        @(negedge clk); rst = 0;

        // R2 / R1 segment masking and windows
        go(32'h00001000, 2, 0, 0, 0, "R2 ram");
        go(32'h80001000, 2, 0, 0, 0, "R1 seg4 ram");
        go(32'hA0001004, 2, 0, 0, 0, "R1 seg5 ram");
        go(32'hBFC00010, 2, 0, 0, 0, "R1 seg5 boot");
        go(32'h9FC00000, 2, 0, 0, 0, "R1 seg4 boot");
        go(32'h3FC00000, 2, 0, 0, 0, "R1 seg1 unmasked");
        go(32'h001FFFFC, 2, 0, 0, 0, "R2 ram last");
        go(32'h00200000, 2, 0, 0, 0, "R5 past ram");
        go(32'h1FC7FFFC, 2, 0, 0, 0, "R2 boot last");
        // R10 expansion-1 reads
        go(32'h1F000000, 0, 0, 0, 0, "R10 exp1 first");
        go(32'h1F07FFFF, 0, 0, 0, 0, "R10 exp1 last");
        go(32'h1F080000, 0, 0, 0, 0, "R5 past exp1");
        go(32'h1F000004, 2, 1, 0, 0, "R10 exp1 store no data");
        // R3 alignment
        go(32'h00000002, 2, 0, 0, 0, "R3 word misaligned");
        go(32'h00000001, 1, 0, 0, 0, "R3 half misaligned");
        go(32'h00000002, 1, 0, 0, 0, "R3 half aligned");
        go(32'h00000003, 0, 0, 0, 0, "R3 byte any");
        go(32'h00000000, 3, 0, 0, 0, "R3 reserved size");
        // R4 isolation
        go(32'h00000002, 2, 1, 0, 1, "R4 iso misaligned");
        go(32'h00000010, 0, 1, 0, 1, "R4 iso ram byte");
        go(32'h30000000, 2, 1, 0, 1, "R4 iso unmapped");
        go(32'h00000010, 2, 0, 0, 1, "R4 iso load passes");
        // R6 dropped stores
        go(32'h1F801060, 2, 1, 5, 0, "R6 memsize");
        go(32'h1F801074, 2, 1, 5, 0, "R6 irq");
        go(32'hFFFE0130, 2, 1, 5, 0, "R6 cache ctl");
        go(32'hFFFE0134, 2, 1, 5, 0, "R5 past cache ctl");
        go(32'h1F801070, 2, 0, 0, 0, "R6 irq load");
        // R7 sound
        go(32'h1F801C02, 1, 1, 0, 0, "R7 sound half");
        go(32'h1F801E7E, 1, 1, 0, 0, "R7 sound last half");
        go(32'h1F801E80, 1, 1, 0, 0, "R5 past sound");
        go(32'h1F801C00, 2, 1, 0, 0, "R7 sound word");
        go(32'h1F801C01, 0, 1, 0, 0, "R7 sound byte");
        go(32'h1F801C04, 1, 0, 0, 0, "R7 sound load");
        // R8 expansion-2
        go(32'h1F802041, 0, 1, 0, 0, "R8 exp2 byte last");
        go(32'h1F802042, 0, 1, 0, 0, "R8 exp2 past");
        go(32'h1F802000, 1, 1, 0, 0, "R8 exp2 half");
        go(32'h1F802000, 2, 1, 0, 0, "R8 exp2 word");
        // R9 system control
        go(32'h1F801000, 2, 1, 32'h1F000000, 0, "R9 off0 good");
        go(32'h1F801000, 2, 1, 32'h1F000001, 0, "R9 off0 bad");
        go(32'h1F801004, 2, 1, 32'h1F802000, 0, "R9 off4 good");
        go(32'h1F801004, 2, 1, 32'h1F000000, 0, "R9 off4 bad");
        go(32'h1F801008, 2, 1, 32'h12345678, 0, "R9 other offset");
        go(32'h1F801020, 2, 0, 0, 0, "R9 load");
        go(32'h1F801024, 2, 0, 0, 0, "R5 past sysctl");
        // R12 forwarded store
        go(32'h00000100, 2, 1, 32'hDEADBEEF, 0, "R12 ram store");
        go(32'hA0000100, 1, 1, 0, 0, "R12 seg5 ram half store");
        // R11 idle
        idle("R11 idle");
        go(32'h1FC00000, 2, 0, 0, 0, "R11 back to back");
        idle("R11 idle again");

        for (int n = 0; n < 600; n++) begin
            logic [31:0] a, wd;
            int sel;
            a = picks[$urandom_range(0, 9)] + 32'($urandom_range(0, 127));
            sel = $urandom_range(0, 2);
            if (a < 32'h20000000 && sel == 1) a = a | 32'h80000000;
            if (a < 32'h20000000 && sel == 2) a = a | 32'hA0000000;
            case ($urandom_range(0, 2))
                0: wd = 32'h1F000000;
                1: wd = 32'h1F802000;
                default: wd = $urandom;
            endcase
            go(a, $urandom_range(0, 3), 1'($urandom_range(0, 1)), wd,
               $urandom_range(0, 7) == 0, "R2 sweep");
            if ($urandom_range(0, 9) == 0) idle("R11 sweep idle");
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule